// File: doc/BRIEF.md
# Audio Serial Port Clock Generator

This block makes the bit and frame clocks for a serial audio port whose receive and transmit halves run on separate bit clocks. Both bit clocks come from one common source. The receive-side clock shifts data into the port and the transmit-side clock shifts data out of it. Because the two can run at different rates, the port can convert between a time-multiplexed stream and a plain stereo stream. The shared source must be the faster of the two bit rates. For a multiplexed input it equals the receive-side clock. For a multiplexed output it equals the transmit-side clock.

In master mode the source is a master clock input, and the block makes the frame clock itself. In slave mode the source is an external bit clock, and the frame clock is an external input that the block follows. Every edge of the frame clock re-phases the derived bit clocks. A small write port selects the mode and sets three ratios: receive bit clock, transmit bit clock and frame length. Everything runs in one fast system clock domain. The slow clocks are sampled, and each generated clock comes with single-cycle rise and fall strobes that downstream shift logic uses as enables.

Top module: `audio_port_clkgen`

## Requirements
- R1: After reset all clock outputs and strobes are low, master mode is selected, and the ratios are 1 (receive), 2 (transmit) and 64 (frame).
- R2: In master mode, nothing toggles until the first falling edge of the master clock. That edge is a frame boundary.
- R3: With ratio N, a bit clock is low for the first N source half-periods after each frame boundary, then high for N, and so on. Its level changes only after a source edge. With N = 1 it follows the source level.
- R4: In master mode the frame clock rises at each boundary. It stays high for F*M source half-periods and low for F*M more, where F is the frame ratio and M is the smaller of the two bit ratios. The next boundary follows.
- R5: Each of the three clocks gives a rise strobe and a fall strobe. A strobe is high for exactly the one system cycle in which the clock first shows its new level.
- R6: A write with address 0 sets the mode from data bit 0 (1 = master, 0 = slave). Address 1 sets the receive ratio, address 2 the transmit ratio and address 3 the frame ratio. A written ratio of 0 is stored as 1.
- R7: Written ratios take effect only at the next frame-clock rising edge. Until then the clocks keep their current pattern.
- R8: In slave mode both bit clocks are divided from the external bit clock, and the frame output follows the sampled external frame clock. The master clock has no effect.
- R9: In slave mode each edge of the external frame clock restarts both bit-clock dividers at the next falling edge of the external bit clock, or at the same edge if they coincide. Both bit clocks then start low.
- R10: A write that changes the mode drives all clock outputs low in the next cycle. They stay low until the first boundary of the new source. In master mode that is a master-clock falling edge. In slave mode it is a rising external frame edge aligned to an external bit-clock falling edge.
- R11: In master mode, edges on the external bit clock input have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic samples on its rising edge |
| rst_n | input | 1 | Active-low reset |
| mclk_i | input | 1 | Master clock, the source in master mode |
| ext_bclk_i | input | 1 | External bit clock, the source in slave mode |
| ext_frame_i | input | 1 | External frame clock used in slave mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 mode, 1 receive ratio, 2 transmit ratio, 3 frame ratio |
| wr_data_i | input | DIV_W | Write data |
| bclk_in_o | output | 1 | Receive-side bit clock |
| bclk_out_o | output | 1 | Transmit-side bit clock |
| frame_o | output | 1 | Frame (left/right) clock |
| bclk_in_rise_o | output | 1 | Strobe: receive bit clock went high |
| bclk_in_fall_o | output | 1 | Strobe: receive bit clock went low |
| bclk_out_rise_o | output | 1 | Strobe: transmit bit clock went high |
| bclk_out_fall_o | output | 1 | Strobe: transmit bit clock went low |
| frame_rise_o | output | 1 | Strobe: frame clock went high |
| frame_fall_o | output | 1 | Strobe: frame clock went low |

## Verification
The assertions check, on every cycle, the local rules:
- bit clocks move only after a source edge or a mode write;
- the master frame clock moves only after a source edge;
- strobes agree with the level they announce;
- a mode change blanks the outputs;
- active ratios change only together with a frame rise;
- a zero ratio write is stored as one.

Only the bench scenarios can show the rest: the full pattern over whole frames, with the low and high run lengths of each clock at several ratio sets. They also show the deferred ratio load, the re-phasing in slave mode after a short frame, the startup after a mode change, and that the unselected source is ignored.

// File: rtl/audio_port_clkgen.sv
module audio_port_clkgen #(
  parameter int DIV_W       = 8,
  parameter int SYNC        = 2,
  parameter int RST_DIV_IN  = 1,
  parameter int RST_DIV_OUT = 2,
  parameter int RST_DIV_FRM = 64,
  parameter bit RST_MASTER  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mclk_i,
  input  logic             ext_bclk_i,
  input  logic             ext_frame_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [DIV_W-1:0] wr_data_i,
  output logic             bclk_in_o,
  output logic             bclk_out_o,
  output logic             frame_o,
  output logic             bclk_in_rise_o,
  output logic             bclk_in_fall_o,
  output logic             bclk_out_rise_o,
  output logic             bclk_out_fall_o,
  output logic             frame_rise_o,
  output logic             frame_fall_o
);

  localparam int PW = 2*DIV_W + 1;

  logic [SYNC-1:0] m_sy, e_sy, f_sy;
  logic m_d, e_d, f_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sy <= '0; e_sy <= '0; f_sy <= '0;
      m_d  <= 1'b0; e_d <= 1'b0; f_d <= 1'b0;
    end else begin
      m_sy <= {m_sy[SYNC-2:0], mclk_i};
      e_sy <= {e_sy[SYNC-2:0], ext_bclk_i};
      f_sy <= {f_sy[SYNC-2:0], ext_frame_i};
      m_d  <= m_sy[SYNC-1];
      e_d  <= e_sy[SYNC-1];
      f_d  <= f_sy[SYNC-1];
    end
  end

  wire m_now = m_sy[SYNC-1];
  wire e_now = e_sy[SYNC-1];
  wire f_now = f_sy[SYNC-1];

  logic             master_q, run_q, pend_q;
  logic [DIV_W-1:0] sh_a, sh_b, sh_f, ac_a, ac_b, ac_f, cnt_a, cnt_b;
  logic [PW-1:0]    pos_q;
  logic             a_q, b_q, f_q;

  wire src_rise = master_q ? (m_now & ~m_d) : (e_now & ~e_d);
  wire src_fall = master_q ? (~m_now & m_d) : (~e_now & e_d);
  wire tick     = src_rise | src_fall;
  wire fr_edge  = f_now ^ f_d;
  wire realign  = src_fall & (fr_edge | pend_q);
  wire mode_wr  = wr_en_i && (wr_addr_i == 2'd0) && (wr_data_i[0] != master_q);
  wire [DIV_W-1:0] wr_val = (wr_data_i == '0) ? DIV_W'(1) : wr_data_i;

  wire [DIV_W-1:0]   fast_div = (ac_a < ac_b) ? ac_a : ac_b;
  wire [2*DIV_W-1:0] half_len = ac_f * fast_div;
  wire [PW-1:0]      last_pos = {half_len, 1'b0} - PW'(1);

  logic             run_n, pend_n, a_n, b_n, f_n, load, restart, step;
  logic [PW-1:0]    pos_n;
  logic [DIV_W-1:0] cnt_a_n, cnt_b_n;

  always_comb begin
    run_n   = run_q;
    pend_n  = pend_q;
    pos_n   = pos_q;
    cnt_a_n = cnt_a;
    cnt_b_n = cnt_b;
    a_n     = a_q;
    b_n     = b_q;
    f_n     = f_q;
    load    = 1'b0;
    restart = 1'b0;
    step    = 1'b0;
    if (master_q) begin
      pend_n = 1'b0;
      if (!run_q) begin
        if (src_fall) begin
          run_n = 1'b1; restart = 1'b1; load = 1'b1; f_n = 1'b1;
        end
      end else if (tick) begin
        if (pos_q == last_pos) begin
          restart = 1'b1; load = 1'b1; f_n = 1'b1;
        end else begin
          step  = 1'b1;
          pos_n = pos_q + PW'(1);
          if (pos_n == {1'b0, half_len}) f_n = 1'b0;
        end
      end
    end else begin
      if (realign)      pend_n = 1'b0;
      else if (fr_edge) pend_n = 1'b1;
      if (realign && f_now) begin
        run_n = 1'b1; restart = 1'b1; load = 1'b1;
      end else if (realign && run_q) begin
        restart = 1'b1;
      end else if (tick && run_q) begin
        step = 1'b1;
      end
      f_n = run_n & f_now;
    end
    if (restart) begin
      pos_n = '0; cnt_a_n = '0; cnt_b_n = '0; a_n = 1'b0; b_n = 1'b0;
    end else if (step) begin
      if (cnt_a == ac_a - DIV_W'(1)) begin
        cnt_a_n = '0; a_n = ~a_q;
      end else begin
        cnt_a_n = cnt_a + DIV_W'(1);
      end
      if (cnt_b == ac_b - DIV_W'(1)) begin
        cnt_b_n = '0; b_n = ~b_q;
      end else begin
        cnt_b_n = cnt_b + DIV_W'(1);
      end
    end
    if (mode_wr) begin
      run_n = 1'b0; pend_n = 1'b0; load = 1'b0;
      a_n = 1'b0; b_n = 1'b0; f_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= RST_MASTER;
      sh_a  <= DIV_W'(RST_DIV_IN);
      sh_b  <= DIV_W'(RST_DIV_OUT);
      sh_f  <= DIV_W'(RST_DIV_FRM);
      ac_a  <= DIV_W'(RST_DIV_IN);
      ac_b  <= DIV_W'(RST_DIV_OUT);
      ac_f  <= DIV_W'(RST_DIV_FRM);
      run_q <= 1'b0; pend_q <= 1'b0; pos_q <= '0;
      cnt_a <= '0; cnt_b <= '0;
      a_q   <= 1'b0; b_q <= 1'b0; f_q <= 1'b0;
      bclk_in_rise_o  <= 1'b0; bclk_in_fall_o  <= 1'b0;
      bclk_out_rise_o <= 1'b0; bclk_out_fall_o <= 1'b0;
      frame_rise_o    <= 1'b0; frame_fall_o    <= 1'b0;
    end else begin
      if (wr_en_i) begin
        case (wr_addr_i)
          2'd0:    master_q <= wr_data_i[0];
          2'd1:    sh_a <= wr_val;
          2'd2:    sh_b <= wr_val;
          default: sh_f <= wr_val;
        endcase
      end
      if (load) begin
        ac_a <= sh_a; ac_b <= sh_b; ac_f <= sh_f;
      end
      run_q <= run_n; pend_q <= pend_n; pos_q <= pos_n;
      cnt_a <= cnt_a_n; cnt_b <= cnt_b_n;
      a_q <= a_n; b_q <= b_n; f_q <= f_n;
      bclk_in_rise_o  <= a_n & ~a_q;
      bclk_in_fall_o  <= ~a_n & a_q;
      bclk_out_rise_o <= b_n & ~b_q;
      bclk_out_fall_o <= ~b_n & b_q;
      frame_rise_o    <= f_n & ~f_q;
      frame_fall_o    <= ~f_n & f_q;
    end
  end

  assign bclk_in_o  = a_q;
  assign bclk_out_o = b_q;
  assign frame_o    = f_q;

  assert_bits_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !mode_wr) |=> ($stable(bclk_in_o) && $stable(bclk_out_o)));

  assert_master_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (master_q && $past(master_q) && !$stable(frame_o)) |-> $past(tick || mode_wr));

  assert_strobe_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_in_rise_o |-> (bclk_in_o && !$past(bclk_in_o)));

  assert_strobe_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_fall_o |-> (!frame_o && $past(frame_o)));

  assert_zero_ratio_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == 2'd1 && wr_data_i == '0) |=> (sh_a == DIV_W'(1)));

  assert_load_at_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (master_q && !$stable(ac_a)) |-> frame_rise_o);

  assert_mode_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (!bclk_in_o && !bclk_out_o && !frame_o));

endmodule

// File: tb/sim_audio_port_clkgen.sv
module sim_audio_port_clkgen;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mclk = 1'b0, ebclk = 1'b0, efr = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic a_o, b_o, f_o, ar_o, af_o, br_o, bf_o, fr_o, ff_o;

  audio_port_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .mclk_i(mclk), .ext_bclk_i(ebclk), .ext_frame_i(efr),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .bclk_in_o(a_o), .bclk_out_o(b_o), .frame_o(f_o),
    .bclk_in_rise_o(ar_o), .bclk_in_fall_o(af_o),
    .bclk_out_rise_o(br_o), .bclk_out_fall_o(bf_o),
    .frame_rise_o(fr_o), .frame_fall_o(ff_o));

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int due;
    logic [8:0] v;
    string tag;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0, zero_at = -1;
  bit done = 1'b0;

  bit m_master = 1'b1, m_run = 1'b0;
  int sa = 1, sb = 2, sf = 64, aa = 1, ab = 2, afr = 64, pos = 0;
  bit pa = 1'b0, pb = 1'b0, pf = 1'b0;

  function automatic int fastest();
    return (aa < ab) ? aa : ab;
  endfunction

  task automatic push(int lat, string tag);
    exp_t e;
    bit a, b, f;
    a = 1'b0; b = 1'b0; f = 1'b0;
    if (m_run) begin
      a = ((pos / aa) % 2) == 1;
      b = ((pos / ab) % 2) == 1;
      f = m_master ? (pos < afr * fastest()) : efr;
    end
    e.due = cyc + lat;
    e.tag = tag;
    e.v = {f, a, b, f & ~pf, ~f & pf, a & ~pa, ~a & pa, b & ~pb, ~b & pb};
    pf = f; pa = a; pb = b;
    q.push_back(e);
  endtask

  task automatic load_ratios();
    aa = sa; ab = sb; afr = sf;
  endtask

  task automatic mclk_edge(string tag);
    @(negedge clk);
    mclk = ~mclk;
    if (m_master) begin
      if (!m_run) begin
        if (!mclk) begin m_run = 1'b1; pos = 0; load_ratios(); end
      end else if (pos == 2 * afr * fastest() - 1) begin
        pos = 0; load_ratios();
      end else begin
        pos++;
      end
    end
    push(3, tag);
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic eb_edge(bit flip, string tag);
    @(negedge clk);
    ebclk = ~ebclk;
    if (flip) efr = ~efr;
    if (!m_master) begin
      if (!ebclk && flip) begin
        if (m_run) pos = 0;
        if (efr) begin m_run = 1'b1; pos = 0; load_ratios(); end
      end else if (m_run) begin
        pos++;
      end
    end
    push(3, tag);
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] ad, logic [7:0] d, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ad; wr_data = d;
    if (ad == 2'd0) begin
      if (d[0] != m_master) begin
        m_master = d[0]; m_run = 1'b0;
        push(1, tag);
      end
    end else begin
      int v;
      v = (d == 0) ? 1 : int'(d);
      if (ad == 2'd1) sa = v; else if (ad == 2'd2) sb = v; else sf = v;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic slave_seg(int len, string tag);
    for (int i = 1; i <= len; i++) eb_edge(i == len, tag);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      logic [8:0] got;
      e = q.pop_front();
      got = {f_o, a_o, b_o, fr_o, ff_o, ar_o, af_o, br_o, bf_o};
      n_chk++;
      if (got !== e.v) begin
        n_bad++;
        $display("FAIL %s cyc %0d: got %b expected %b", e.tag, cyc, got, e.v);
      end
      zero_at = cyc + 1;
    end else if (cyc == zero_at) begin
      n_chk++;
      if ({fr_o, ff_o, ar_o, af_o, br_o, bf_o} !== 6'b0) begin
        n_bad++;
        $display("FAIL R5 cyc %0d: strobes %b expected 000000",
                 cyc, {fr_o, ff_o, ar_o, af_o, br_o, bf_o});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if ({f_o, a_o, b_o, fr_o, ff_o, ar_o, af_o, br_o, bf_o} !== 9'b0) begin
      n_bad++;
      $display("FAIL R1: got %b expected 000000000",
               {f_o, a_o, b_o, fr_o, ff_o, ar_o, af_o, br_o, bf_o});
    end
    // R1 R2 R3 R4 R5: default ratios in master mode over two frames
    for (int i = 0; i < 270; i++) mclk_edge("R1 R2 R3 R4 R5");
    // R7: new ratios wait for the next frame rise
    wr(2'd1, 8'd4, "R7");
    wr(2'd2, 8'd2, "R7");
    wr(2'd3, 8'd8, "R7");
    for (int i = 0; i < 210; i++) mclk_edge("R6 R7 R3 R4");
    // R6: zero ratio becomes one, odd ratios
    wr(2'd1, 8'd0, "R6");
    wr(2'd2, 8'd3, "R6");
    wr(2'd3, 8'd5, "R6");
    for (int i = 0; i < 170; i++) mclk_edge("R6 R3 R4");
    // R11: external bit clock ignored in master mode
    for (int i = 0; i < 6; i++) eb_edge(1'b0, "R11");
    // R10 R8 R9: go slave
    wr(2'd1, 8'd1, "R6");
    wr(2'd2, 8'd2, "R6");
    wr(2'd0, 8'd0, "R10");
    for (int i = 0; i < 8; i++) mclk_edge("R8 R10");
    slave_seg(4, "R10 R8");
    slave_seg(16, "R8");
    slave_seg(16, "R8");
    slave_seg(6, "R9");
    slave_seg(16, "R9 R8");
    wr(2'd2, 8'd4, "R7");
    slave_seg(10, "R9 R7");
    slave_seg(16, "R8 R7");
    slave_seg(16, "R8");
    // R10: back to master
    wr(2'd0, 8'd1, "R10");
    for (int i = 0; i < 40; i++) mclk_edge("R10 R2");
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule